// File: doc/BRIEF.md
# PRP Read-Data Write Splitter

This block sits on the data path of a storage controller. It takes the data of one read command and turns it into a series of memory-write requests toward host memory. At start it captures the first page pointer, the second pointer, the zero-based block count and the selected maximum payload size. A stream of data dwords then flows through it. Each dword leaves as one beat of a write request. The first beat of a request carries the target address and the request length in dwords.

Every request ends at whichever comes first: the maximum payload size, the next 4 KiB host page boundary, or the end of the transfer. When the first pointer has a page offset, the first page takes only the bytes that remain in that page. The rest of the data goes to the page named by the second pointer. A command whose data would touch more than two host pages is refused at start.

Top module: `prp_wr_split`

## Requirements
- R1: While reset is held, and in idle after reset, `wr_valid_o`, `dat_ready_o`, `done_o` and `err_o` are low, even when `dat_valid_i` is high.
- R2: The transfer length is (`nlb_i` + 1) × 512 bytes. The lengths of all emitted requests add up to exactly this number of dwords. The data dwords leave in the order they arrived.
- R3: `wr_len_o` (in dwords) never exceeds the payload limit selected by `mps_sel_i`. The codes are 0 → 128 bytes, 1 → 256 bytes, 2 → 512 bytes, and 3 → 128 bytes.
- R4: No request crosses a 4 KiB page boundary. A request shorter than the payload limit appears only at a page end or at the end of the transfer.
- R5: The first request goes to `prp1_i` with bits 1:0 cleared. Data that does not fit in the first page continues at `prp2_i` with bits 11:0 cleared.
- R6: Requests come out in ascending address order within each page. `wr_sop_o` marks the first beat of a request and `wr_eop_o` marks its last beat. `wr_addr_o` and `wr_len_o` are valid on the first beat.
- R7: `done_o` is high for exactly one cycle, in the cycle after the final beat is accepted.
- R8: When the page offset plus the transfer length exceeds 8192 bytes, `err_o` is high for one cycle, in the cycle after `start_i` is sampled. In that case no beat is emitted and `dat_ready_o` stays low. A transfer of exactly 8192 bytes with offset zero is accepted.
- R9: While `wr_ready_i` is low, `dat_ready_o` is low and no data is lost or duplicated.
- R10: `start_i` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (sampled in idle) |
| prp1_i | input | 64 | First page pointer with page offset |
| prp2_i | input | 64 | Second page pointer (page aligned) |
| nlb_i | input | 8 | Zero-based count of 512-byte blocks |
| mps_sel_i | input | 2 | Payload limit code |
| dat_valid_i | input | 1 | Input dword valid |
| dat_i | input | 32 | Input dword |
| dat_ready_o | output | 1 | Input dword accepted |
| wr_valid_o | output | 1 | Write beat valid |
| wr_ready_i | input | 1 | Write beat accepted downstream |
| wr_sop_o | output | 1 | First beat of a request |
| wr_eop_o | output | 1 | Last beat of a request |
| wr_addr_o | output | 64 | Request byte address |
| wr_len_o | output | 8 | Request length in dwords |
| wr_data_o | output | 32 | Beat data |
| done_o | output | 1 | Transfer finished pulse |
| err_o | output | 1 | Transfer refused pulse |

## Verification
The hardest case to reach is the switch to the second pointer in the middle of a transfer. For this to happen, the first pointer's offset must leave a page remainder that is not a whole number of payloads, and the switch must coincide with stalls on both sides. The stimulus picks offsets such as 0xE80 and 0xF83, which force a short request at the page end. It then throttles `wr_ready_i` and `dat_valid_i` in different rhythms while a stray `start_i` arrives mid-transfer. Separate cases probe the two-page limit: a full 8192-byte transfer from offset zero is accepted, while the same length with a 4-byte offset is refused.

// File: rtl/prp_split_pkg.sv
package prp_split_pkg;
  localparam int unsigned MPS_MAX_B = 512;

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  function automatic logic [9:0] mps_bytes(input logic [1:0] sel);
    case (sel)
      2'd1:    return 10'd256;
      2'd2:    return 10'd512;
      default: return 10'd128; // code 3 falls back to the smallest size
    endcase
  endfunction
endpackage

// File: rtl/prp_start_chk.sv
module prp_start_chk #(
  parameter int NLB_W  = 8,
  parameter int BLK_SH = 9,
  parameter int PG_SH  = 12,
  parameter int LEN_W  = NLB_W + 1 + BLK_SH
) (
  input  logic [NLB_W-1:0] nlb_i,
  input  logic [PG_SH-1:0] off_i,
  output logic [LEN_W-1:0] len_o,
  output logic             ovf_o
);
  localparam logic [LEN_W:0] LIM = (LEN_W+1)'(2) << PG_SH;

  logic [NLB_W:0] blk_cnt;
  logic [LEN_W:0] tot;

  always_comb begin
    blk_cnt = {1'b0, nlb_i} + (NLB_W+1)'(1);
    len_o   = LEN_W'(blk_cnt) << BLK_SH;
    tot     = {1'b0, len_o} + (LEN_W+1)'(off_i);
    ovf_o   = tot > LIM;
  end
endmodule

// File: rtl/prp_len_calc.sv
module prp_len_calc #(
  parameter int LEN_W = 18,
  parameter int PG_SH = 12
) (
  input  logic [PG_SH-1:0] off_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [LEN_W-1:0] mps_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] PG_B = LEN_W'(1) << PG_SH;

  logic [LEN_W-1:0] pg_rem, lim;

  always_comb begin
    pg_rem = PG_B - LEN_W'(off_i);
    lim    = (mps_i < pg_rem) ? mps_i : pg_rem;
    len_o  = (rem_i < lim) ? rem_i : lim;
  end
endmodule

// File: rtl/prp_beat_ctr.sv
module prp_beat_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] len_dw_i,
  output logic             sop_o,
  output logic             eop_o
);
  logic [CNT_W-1:0] cnt_q;

  assign sop_o = (cnt_q == '0);
  assign eop_o = (cnt_q == len_dw_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (fire_i && eop_o) cnt_q <= '0;
    else if (fire_i)          cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_beat_in_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_dw_i != '0) |-> (cnt_q < len_dw_i));
endmodule

// File: rtl/prp_wr_split.sv
module prp_wr_split
  import prp_split_pkg::*;
#(
  parameter int AW         = 64,
  parameter int DW         = 32,
  parameter int NLB_W      = 8,
  parameter int BLK_BYTES  = 512,
  parameter int PAGE_BYTES = 4096,
  localparam int LDW_W     = $clog2(MPS_MAX_B / 4) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    prp1_i,
  input  logic [AW-1:0]    prp2_i,
  input  logic [NLB_W-1:0] nlb_i,
  input  logic [1:0]       mps_sel_i,
  input  logic             dat_valid_i,
  input  logic [DW-1:0]    dat_i,
  output logic             dat_ready_o,
  output logic             wr_valid_o,
  input  logic             wr_ready_i,
  output logic             wr_sop_o,
  output logic             wr_eop_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [LDW_W-1:0] wr_len_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int BLK_SH = $clog2(BLK_BYTES);
  localparam int PG_SH  = $clog2(PAGE_BYTES);
  localparam int LEN_W  = NLB_W + 1 + BLK_SH;
  localparam logic [LEN_W-1:0] PG_B = LEN_W'(1) << PG_SH;

  st_e              st_q;
  logic [AW-1:0]    addr_q, pg2_q, addr_nx, prp1_al, prp2_al;
  logic [LEN_W-1:0] rem_q, mps_q, len_b, xfer_len;
  logic             ovf, fire, sop, eop, done_q, err_q, run;

  assign prp1_al = prp1_i & ~AW'(3);
  assign prp2_al = prp2_i & ~AW'(PAGE_BYTES - 1);

  prp_start_chk #(.NLB_W(NLB_W), .BLK_SH(BLK_SH), .PG_SH(PG_SH), .LEN_W(LEN_W)) u_chk (
    .nlb_i (nlb_i),
    .off_i (prp1_al[PG_SH-1:0]),
    .len_o (xfer_len),
    .ovf_o (ovf)
  );

  prp_len_calc #(.LEN_W(LEN_W), .PG_SH(PG_SH)) u_len (
    .off_i (addr_q[PG_SH-1:0]),
    .rem_i (rem_q),
    .mps_i (mps_q),
    .len_o (len_b)
  );

  prp_beat_ctr #(.CNT_W(LDW_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .len_dw_i (wr_len_o),
    .sop_o    (sop),
    .eop_o    (eop)
  );

  assign run         = (st_q == ST_RUN);
  assign wr_valid_o  = run && dat_valid_i;
  assign dat_ready_o = run && wr_ready_i;
  assign fire        = wr_valid_o && wr_ready_i;
  assign wr_data_o   = dat_i;
  assign wr_addr_o   = addr_q;
  assign wr_len_o    = LDW_W'(len_b >> 2);
  assign wr_sop_o    = sop;
  assign wr_eop_o    = eop;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign addr_nx     = addr_q + AW'(len_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      pg2_q  <= '0;
      rem_q  <= '0;
      mps_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_i) begin
          if (ovf) begin
            err_q <= 1'b1;
          end else begin
            st_q   <= ST_RUN;
            addr_q <= prp1_al;
            pg2_q  <= prp2_al;
            rem_q  <= xfer_len;
            mps_q  <= LEN_W'(mps_bytes(mps_sel_i));
          end
        end
      end else if (fire && eop) begin
        rem_q <= rem_q - len_b;
        if (rem_q == len_b) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end else if (addr_nx[PG_SH-1:0] == '0) begin
          addr_q <= pg2_q; // first page used up
        end else begin
          addr_q <= addr_nx;
        end
      end
    end
  end

  assert_req_le_mps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (len_b != '0) && (len_b <= mps_q));
  assert_no_page_cross_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_sop_o) |-> (LEN_W'(wr_addr_o[PG_SH-1:0]) + len_b <= PG_B));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_after_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(start_i) && !done_o && !wr_valid_o);
  assert_stall_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_i |-> !dat_ready_o);
endmodule

// File: tb/sim_prp_wr_split.sv
module sim_prp_wr_split;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] d;
    logic [63:0] a;
    logic [7:0]  l;
    bit          sop;
    bit          eop;
  } beat_t;

  logic        clk = 0, rst_n = 0, start = 0, dat_valid = 0, wr_ready = 1;
  logic [63:0] prp1 = 0, prp2 = 0;
  logic [7:0]  nlb = 0;
  logic [1:0]  sel = 0;
  logic [31:0] dat = 0;
  logic        dat_ready, wr_valid, wr_sop, wr_eop, done, err;
  logic [63:0] wr_addr;
  logic [7:0]  wr_len;
  logic [31:0] wr_data;

  int    checks = 0, fails = 0, cyc = 0;
  bit    bp_en = 0;
  string cur_tag = "R2";
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prp_wr_split u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prp1_i(prp1), .prp2_i(prp2),
    .nlb_i(nlb), .mps_sel_i(sel), .dat_valid_i(dat_valid), .dat_i(dat),
    .dat_ready_o(dat_ready), .wr_valid_o(wr_valid), .wr_ready_i(wr_ready),
    .wr_sop_o(wr_sop), .wr_eop_o(wr_eop), .wr_addr_o(wr_addr), .wr_len_o(wr_len),
    .wr_data_o(wr_data), .done_o(done), .err_o(err));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 wr_ready = !bp_en || (cyc % 3 != 0);
  end

  // monitor: compare each accepted beat with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, cur_tag, "unexpected beat addr", wr_addr, 0);
      end else begin
        beat_t e;
        e = exp_q.pop_front();
        chk(wr_data == e.d && wr_sop == e.sop && wr_eop == e.eop, cur_tag,
            "beat data/sop/eop", {wr_data, 30'd0, wr_sop, wr_eop}, {e.d, 30'd0, e.sop, e.eop});
        if (e.sop)
          chk(wr_addr == e.a && wr_len == e.l, cur_tag, "request addr/len",
              {wr_addr[55:0], wr_len}, {e.a[55:0], e.l});
      end
    end
  end

  task automatic run_xfer(input logic [63:0] p1, input logic [63:0] p2, input int nb,
                          input logic [1:0] s, input bit bp, input bit poke, input string tag);
    int mps, len, off, ndw, rem, l, idx, k;
    bit exp_err, f;
    logic [63:0] a;
    logic [31:0] base;
    cur_tag = tag;
    bp_en   = bp;
    mps     = (s == 1) ? 256 : (s == 2) ? 512 : 128;
    len     = (nb + 1) * 512;
    off     = int'(p1[11:0]) & ~3;
    exp_err = (off + len) > 8192;
    ndw     = len / 4;
    base    = 32'h5A00_0000 + 32'(nb * 4099 + int'(s) * 77 + off);
    if (!exp_err) begin
      a = p1 & ~64'h3; rem = len; idx = 0;
      while (rem > 0) begin
        l = 4096 - int'(a[11:0]);
        if (mps < l) l = mps;
        if (rem < l) l = rem;
        for (int j = 0; j < l / 4; j++) begin
          exp_q.push_back('{d: base + 32'(idx), a: a, l: 8'(l / 4),
                            sop: (j == 0), eop: (j == l / 4 - 1)});
          idx++;
        end
        rem -= l;
        a += 64'(l);
        if (a[11:0] == 0 && rem > 0) a = p2 & ~64'hFFF;
      end
    end
    @(posedge clk); #1;
    prp1 = p1; prp2 = p2; nlb = 8'(nb); sel = s; start = 1;
    @(posedge clk); #1;
    start = 0;
    chk(err == exp_err, "R8", "err_o after start", 64'(err), 64'(exp_err));
    if (exp_err) begin
      dat_valid = 1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(!dat_ready && !wr_valid, "R8", "ready/valid after refusal",
            64'({dat_ready, wr_valid}), 0);
      end
      @(posedge clk); #1;
      dat_valid = 0;
      return;
    end
    idx = 0; k = 0;
    while (idx < ndw) begin
      dat_valid = (k % 5 != 4);
      dat = base + 32'(idx);
      if (poke && k == 3) begin
        start = 1; prp1 = 64'h7777_0000; nlb = 8'd3; sel = 2'd2; // R10: ignored
      end else begin
        start = 0;
      end
      @(negedge clk);
      f = dat_valid && dat_ready;
      if (!wr_ready) chk(!dat_ready, "R9", "dat_ready_o during stall", 64'(dat_ready), 0);
      @(posedge clk); #1;
      if (f) idx++;
      k++;
    end
    start = 0;
    dat_valid = 0;
    chk(done == 1'b1, "R7", "done_o after last beat", 64'(done), 1);
    chk(exp_q.size() == 0, "R2", "leftover expected beats", 64'(exp_q.size()), 0);
    @(posedge clk); #1;
    chk(done == 1'b0, "R7", "done_o one cycle", 64'(done), 0);
    chk(!wr_valid && !dat_ready, "R10", "idle after transfer", 64'({wr_valid, dat_ready}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    dat_valid = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(!wr_valid && !dat_ready && !done && !err, "R1", "outputs in reset",
        64'({wr_valid, dat_ready, done, err}), 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(!wr_valid && !dat_ready && !done && !err, "R1", "outputs idle after reset",
        64'({wr_valid, dat_ready, done, err}), 0);
    dat_valid = 0;
    run_xfer(64'h0000_0000_FEB8_4000, 64'h0, 7, 2'd1, 0, 0, "R3"); // 16 x 64 dw
    run_xfer(64'h0000_0000_FEB8_4000, 64'h0, 7, 2'd0, 0, 0, "R3"); // 32 x 32 dw
    run_xfer(64'h0000_0000_FEB8_4000, 64'h0, 7, 2'd2, 0, 0, "R3"); // 8 x 128 dw
    run_xfer(64'h0000_0000_1234_5000, 64'h0, 3, 2'd3, 0, 0, "R3"); // code 3 -> 128 B
    run_xfer(64'h0000_0001_0000_0E80, 64'h0000_0002_0000_0000, 1, 2'd1, 1, 0, "R4");
    run_xfer(64'h0000_0003_0000_0F83, 64'h0000_0004_0000_0ABC, 0, 2'd2, 0, 0, "R5");
    run_xfer(64'h0000_0005_0000_0000, 64'h0000_0006_0000_0000, 15, 2'd2, 0, 0, "R6");
    run_xfer(64'h0000_0005_0000_0004, 64'h0000_0006_0000_0000, 15, 2'd2, 0, 0, "R8");
    run_xfer(64'h0000_0007_0000_0C00, 64'h0000_0008_0000_0000, 3, 2'd1, 1, 1, "R10");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule